// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block produces the chip-select, output-enable and write-enable waveforms for one external asynchronous memory region, such as a NAND or SRAM device. Each access runs through three timed phases: setup, strobe and hold. The length of each phase comes from a single 32-bit timing word. Reads and writes have separate sets of counts in that word. After a read, a turnaround gap keeps the bus quiet before the next access can begin.

Requests come in on a valid/ready handshake that carries the direction, the address and the write data. The block holds `req_ready` low for the whole of an access, including any turnaround gap, so a requester keeps its request asserted until it sees ready. The response is a single-cycle `rsp_valid` pulse that carries the read data. The response has no back-pressure: the requester must capture the data in the cycle of the pulse. The timing word is loaded through a plain write strobe.

Top module: `amem_strobe_seq`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is low, `rsp_valid` is low and `req_ready` is high. The reset timing word is 0x0432018C.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle and `cfg_we` is low in that same cycle. A request offered while `req_ready` is low waits.
- R3: Timing word fields are write setup [29:26], write strobe [25:20] and write hold [19:17]. A write holds chip-select low and `mem_dq_oe` high for (setup+1)+(strobe+1)+(hold+1) cycles, starting in the cycle after acceptance. `mem_we_n` is low exactly during the strobe+1 cycles that follow the setup phase.
- R4: Timing word fields are read setup [16:13], read strobe [12:7] and read hold [6:4]. A read follows the same three-phase pattern, with `mem_oe_n` low during the strobe phase and `mem_dq_oe` low throughout.
- R5: Read data is taken from `mem_dq_in` on the last cycle of the strobe phase. It is returned on `rsp_rdata`.
- R6: `rsp_valid` is high for exactly one cycle, the first cycle after the hold phase, for both reads and writes.
- R7: After a write, `req_ready` returns in the first cycle after the hold phase. After a read, it stays low for a further turnaround+1 cycles, where turnaround is field [3:2].
- R8: When bit 31 is set, chip-select is low only during the strobe phase. When bit 31 is clear, chip-select spans setup, strobe and hold.
- R9: Width field [1:0] = 1 selects a 16-bit bus. Any other value selects an 8-bit bus. On an 8-bit bus the upper byte of `mem_dq_out` is driven as zero and the upper byte of `rsp_rdata` is returned as zero.
- R10: A timing word write made while an access or turnaround is in progress is ignored. The next access still uses the previous timing. A write made while idle applies to the next accepted request.
- R11: Bit 30 of the timing word has no effect on any output.
- R12: `mem_oe_n` and `mem_we_n` are never low together, and neither is low unless `mem_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_wdata | input | 32 | Timing word value |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with `rsp_valid` after a read |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | ADDR_W | External address |
| mem_dq_out | output | DATA_W | External data out |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | DATA_W | External data in |

## Verification
Counting from the accepting clock edge, with S, T, H and A the setup, strobe, hold and turnaround fields, the due times are:
- The setup phase covers cycles 0 to S.
- The strobe phase covers cycles S+1 to S+T+1.
- Read data is sampled at the edge that closes cycle S+T+1.
- `rsp_valid` is due in cycle S+T+H+3.
- `req_ready` returns in cycle S+T+H+3 after a write, or S+T+H+A+4 after a read.

The bench recomputes these indices from its own copy of the timing word for every access. It compares every pin in every cycle of the access, sampling at the falling edge. It drives the expected read word on `mem_dq_in` only in cycle S+T+1 and its complement in all other cycles, so a sample taken one cycle early or late returns the wrong word.

// File: rtl/amem_pkg.sv
package amem_pkg;

  localparam int CFG_W = 32;
  localparam int CNT_W = 6;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_TURN
  } phase_e;

  // Field layout follows bit order 31 down to 0 of the timing word.
  typedef struct packed {
    logic       cs_in_strobe;
    logic       wait_en;
    logic [3:0] wr_setup;
    logic [5:0] wr_strobe;
    logic [2:0] wr_hold;
    logic [3:0] rd_setup;
    logic [5:0] rd_strobe;
    logic [2:0] rd_hold;
    logic [1:0] gap;
    logic [1:0] width;
  } timing_t;

  function automatic logic is_wide(input logic [1:0] w);
    return w == 2'b01;
  endfunction

endpackage

// File: rtl/amem_cfg_reg.sv
module amem_cfg_reg
  import amem_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_WORD = 32'h0432_018C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output timing_t          timing
);

  logic [CFG_W-1:0] word_q;

  // Writes land only between accesses so a running access keeps its timing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= RESET_WORD;
    end else if (cfg_we && idle) begin
      word_q <= cfg_wdata;
    end
  end

  assign timing = timing_t'(word_q);

endmodule

// File: rtl/amem_phase_fsm.sv
module amem_phase_fsm
  import amem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  timing_t           timing,
  input  logic              cfg_we,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] rd_lanes,
  output logic              req_ready,
  output logic              idle,
  output phase_e            phase,
  output logic              wr_dir,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              cnt_zero;
  logic              accept;

  logic unused_timing;
  assign unused_timing = ^{timing.cs_in_strobe, timing.wait_en, timing.width};

  assign idle      = (phase_q == PH_IDLE);
  assign req_ready = idle && !cfg_we;
  assign accept    = req_valid && req_ready;
  assign cnt_zero  = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q <= PH_SETUP;
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            cnt_q   <= req_write ? CNT_W'(timing.wr_setup) : CNT_W'(timing.rd_setup);
          end
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            phase_q <= PH_STROBE;
            cnt_q   <= wr_q ? CNT_W'(timing.wr_strobe) : CNT_W'(timing.rd_strobe);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_STROBE: begin
          if (cnt_zero) begin
            phase_q <= PH_HOLD;
            cnt_q   <= wr_q ? CNT_W'(timing.wr_hold) : CNT_W'(timing.rd_hold);
            if (!wr_q) rdata_q <= rd_lanes;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_HOLD: begin
          if (cnt_zero) begin
            done_q <= 1'b1;
            if (wr_q) begin
              phase_q <= PH_IDLE;
            end else begin
              phase_q <= PH_TURN;
              cnt_q   <= CNT_W'(timing.gap);
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_TURN: begin
          if (cnt_zero) phase_q <= PH_IDLE;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase     = phase_q;
  assign wr_dir    = wr_q;
  assign rsp_valid = done_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/amem_pin_drive.sv
module amem_pin_drive
  import amem_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  phase_e            phase,
  input  logic              wr_dir,
  input  logic              cs_in_strobe,
  input  logic              wide,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [DATA_W-1:0] dq_in,
  output logic              cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_lanes
);

  localparam int LANES = DATA_W / 8;

  logic in_access;
  logic in_strobe;

  always_comb begin
    in_access = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    in_strobe = (phase == PH_STROBE);
    cs_n  = cs_in_strobe ? !in_strobe : !in_access;
    oe_n  = !(in_strobe && !wr_dir);
    we_n  = !(in_strobe && wr_dir);
    dq_oe = in_access && wr_dir;
  end

  // Byte lane 0 is always live; upper lanes only on the wide bus.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_on;
    if (g == 0) begin : g_base
      assign lane_on = 1'b1;
    end else begin : g_upper
      assign lane_on = wide;
    end
    assign dq_out[g*8 +: 8]   = lane_on ? wdata_q[g*8 +: 8] : 8'h00;
    assign rd_lanes[g*8 +: 8] = lane_on ? dq_in[g*8 +: 8]   : 8'h00;
  end

endmodule

// File: rtl/amem_strobe_seq.sv
module amem_strobe_seq
  import amem_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter logic [CFG_W-1:0]  CFG_RESET = 32'h0432_018C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  timing_t           timing;
  logic              idle;
  phase_e            phase;
  logic              wr_dir;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_lanes;

  amem_cfg_reg #(.RESET_WORD(CFG_RESET)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle      (idle),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .timing    (timing)
  );

  amem_phase_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .timing    (timing),
    .cfg_we    (cfg_we),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_lanes  (rd_lanes),
    .req_ready (req_ready),
    .idle      (idle),
    .phase     (phase),
    .wr_dir    (wr_dir),
    .addr_q    (mem_addr),
    .wdata_q   (wdata_q),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  amem_pin_drive #(.DATA_W(DATA_W)) u_pins (
    .phase        (phase),
    .wr_dir       (wr_dir),
    .cs_in_strobe (timing.cs_in_strobe),
    .wide         (is_wide(timing.width)),
    .wdata_q      (wdata_q),
    .dq_in        (mem_dq_in),
    .cs_n         (mem_cs_n),
    .oe_n         (mem_oe_n),
    .we_n         (mem_we_n),
    .dq_oe        (mem_dq_oe),
    .dq_out       (mem_dq_out),
    .rd_lanes     (rd_lanes)
  );

endmodule

// File: rtl/amem_seq_checker.sv
module amem_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic oe_n,
  input logic we_n,
  input logic dq_oe,
  input logic req_valid,
  input logic req_ready,
  input logic cfg_we,
  input logic rsp_valid
);

  a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  a_r12_strobe_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || !we_n) |-> !cs_n);

  a_r2_ready_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && oe_n && we_n && !dq_oe));

  a_r2_cfg_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !req_ready);

  a_r2_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

endmodule

bind amem_strobe_seq amem_seq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (mem_cs_n),
  .oe_n      (mem_oe_n),
  .we_n      (mem_we_n),
  .dq_oe     (mem_dq_oe),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cfg_we    (cfg_we),
  .rsp_valid (rsp_valid)
);

// File: tb/amem_strobe_seq_tb_top.sv
module amem_strobe_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] mem_dq_in = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] mem_addr;
  logic [15:0] mem_dq_out;

  int n_tot = 0;
  int n_fail = 0;
  logic [31:0] cur_cfg = 32'h0432_018C;

  always #5 clk = ~clk;

  amem_strobe_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C96;
  endfunction

  // Phase lengths from the bench copy of the timing word.
  function automatic int f_setup(input logic [31:0] w, input bit wr);
    return wr ? int'(w[29:26]) : int'(w[16:13]);
  endfunction
  function automatic int f_strobe(input logic [31:0] w, input bit wr);
    return wr ? int'(w[25:20]) : int'(w[12:7]);
  endfunction
  function automatic int f_hold(input logic [31:0] w, input bit wr);
    return wr ? int'(w[19:17]) : int'(w[6:4]);
  endfunction

  task automatic run_access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                            input bit junk, input bit pre, input logic [31:0] pre_word,
                            output int errs);
    int s, t, h, g, done_at, ready_at, f0;
    bit sel, wide, in_acc, in_str;
    logic [15:0] good, exp_rd, exp_out;
    string tg;
    f0 = n_fail;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (pre) begin
      cfg_we = 1'b1; cfg_wdata = pre_word;
      #1;
      chk(req_ready == 1'b0, "R2 ready low during cfg write", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
      cfg_we = 1'b0;
      cur_cfg = pre_word;
      #1;
    end
    while (!req_ready) @(negedge clk);
    s = f_setup(cur_cfg, wr); t = f_strobe(cur_cfg, wr); h = f_hold(cur_cfg, wr);
    g = int'(cur_cfg[3:2]); sel = cur_cfg[31]; wide = (cur_cfg[1:0] == 2'b01);
    done_at = s + t + h + 3;
    ready_at = wr ? done_at : done_at + g + 1;
    good = mem_word(a);
    exp_rd = wide ? good : {8'h00, good[7:0]};
    exp_out = wide ? d : {8'h00, d[7:0]};
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i <= ready_at; i++) begin
      if (i > 0) @(negedge clk);
      in_acc = (i < done_at);
      in_str = (i >= s + 1) && (i < s + t + 2);
      tg = sel ? "R8 cs in strobe mode" : (wr ? "R3 write cs" : "R4 read cs");
      chk(mem_cs_n == (sel ? !in_str : !in_acc), tg, {31'd0, mem_cs_n}, {31'd0, sel ? !in_str : !in_acc});
      chk(mem_we_n == !(in_str && wr), "R3 we strobe", {31'd0, mem_we_n}, {31'd0, !(in_str && wr)});
      chk(mem_oe_n == !(in_str && !wr), "R4 oe strobe", {31'd0, mem_oe_n}, {31'd0, !(in_str && !wr)});
      chk(!(!mem_oe_n && !mem_we_n), "R12 strobes overlap", {30'd0, mem_oe_n, mem_we_n}, 32'd3);
      chk(mem_dq_oe == (wr && in_acc), "R3 data enable", {31'd0, mem_dq_oe}, {31'd0, wr && in_acc});
      if (wr && in_acc)
        chk(mem_dq_out == exp_out, wide ? "R3 write data" : "R9 narrow write data", {16'd0, mem_dq_out}, {16'd0, exp_out});
      if (in_acc) chk(mem_addr == a, "R3 address", {16'd0, mem_addr}, {16'd0, a});
      chk(rsp_valid == (i == done_at), "R6 done pulse", {31'd0, rsp_valid}, {31'd0, i == done_at});
      if (i == done_at && !wr)
        chk(rsp_rdata == exp_rd, wide ? "R5 read data" : "R9 narrow read data", {16'd0, rsp_rdata}, {16'd0, exp_rd});
      chk(req_ready == (i >= ready_at), "R7 ready return", {31'd0, req_ready}, {31'd0, i >= ready_at});
      mem_dq_in = (i == s + t + 1) ? good : ~good;
      if (junk) begin
        cfg_we = (i == 1);
        cfg_wdata = ~cur_cfg;
      end
    end
    errs = n_fail - f0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_tot++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    int e;
    logic [31:0] w;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes in reset", {29'd0, mem_cs_n, mem_oe_n, mem_we_n}, 32'd7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_dq_oe && !rsp_valid, "R1 outputs after reset", {30'd0, mem_dq_oe, rsp_valid}, 32'd0);
    chk(req_ready == 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);

    // Reset timing word: write then read, back to back.
    run_access(1'b1, 16'h1234, 16'hBEEF, 1'b0, 1'b0, 32'd0, e);
    run_access(1'b0, 16'h00A5, 16'h0000, 1'b0, 1'b0, 32'd0, e);
    // Minimum durations, 16-bit bus.
    run_access(1'b1, 16'h0F0F, 16'hCAFE, 1'b0, 1'b1, 32'h0000_0001, e);
    run_access(1'b0, 16'h8001, 16'h0000, 1'b0, 1'b0, 32'd0, e);
    // Chip-select only during strobe, mixed lengths.
    run_access(1'b1, 16'h4321, 16'h5A5A, 1'b0, 1'b1, 32'h8864_A4E9, e);
    run_access(1'b0, 16'h7777, 16'h0000, 1'b0, 1'b0, 32'd0, e);
    // Width value 2 behaves as narrow bus.
    run_access(1'b0, 16'hF00D, 16'h0000, 1'b0, 1'b1, 32'h0422_214E, e);
    run_access(1'b1, 16'h0101, 16'hFFEE, 1'b0, 1'b0, 32'd0, e);
    // R10: timing write during a busy access is ignored.
    run_access(1'b0, 16'h2222, 16'h0000, 1'b1, 1'b1, 32'h0C30_4A9D, e);
    run_access(1'b1, 16'h3333, 16'h9876, 1'b0, 1'b0, 32'd0, e);
    chk(e == 0, "R10 busy timing write ignored", e, 32'd0);
    // R11: bit 30 set, identical timing expected.
    run_access(1'b0, 16'h5555, 16'h0000, 1'b0, 1'b1, 32'h4C30_4A9D, e);
    chk(e == 0, "R11 wait bit read", e, 32'd0);
    run_access(1'b1, 16'h6666, 16'h1357, 1'b0, 1'b0, 32'd0, e);
    chk(e == 0, "R11 wait bit write", e, 32'd0);

    for (int k = 0; k < 150; k++) begin
      w = $urandom;
      run_access(1'($urandom), 16'($urandom), 16'($urandom),
                 ($urandom % 8) == 0, ($urandom % 4) == 0, w, e);
    end

    @(negedge clk);
    chk(req_ready && mem_cs_n, "R2 idle at end", {30'd0, req_ready, mem_cs_n}, 32'd3);
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

endmodule